// File: doc/BRIEF.md
# Privilege Mode Control Unit

This block holds the one-bit processor mode and enforces the rules that keep user code away from protected operations. Supervisor mode is encoded as 0 and user mode as 1. The block comes out of reset in supervisor mode. The only way into user mode is an explicit enter-user request issued from supervisor mode. Every interrupt, software call, fault or illegal attempt returns the processor to supervisor mode.

An external decoder presents each instruction with a valid strobe and a privileged flag. The block answers in the same cycle with an execute-enable, which stays low for a privileged operation attempted in user mode. On the following clock edge the block raises a one-cycle trap request with a 2-bit cause code. At the same edge it drops the mode back to supervisor. Vector fetch, state saving and service routines live outside the block.

Top module: `privilege_mode_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the mode output is 0 (supervisor) and the trap output is 0. Asserting the active-low reset clears the mode at once, without waiting for a clock.
- R2: An enter-user request in supervisor mode, with no trap event in the same cycle, sets the mode to 1 (user) at the next clock edge and raises no trap.
- R3: A valid privileged instruction in supervisor mode has execute-enable 1 in the same cycle, raises no trap and leaves the mode at 0.
- R4: A valid non-privileged instruction has execute-enable 1 in either mode, and execute-enable is 0 when no instruction is valid.
- R5: A valid privileged instruction in user mode has execute-enable 0 in the same cycle. At the next edge it raises a trap with cause 2'b10 (illegal operation) and sets the mode to 0.
- R6: An enter-user request made in user mode counts as an illegal privileged operation: trap with cause 2'b10, mode 0.
- R7: A high level on any external interrupt line raises a trap with cause 2'b00 at the next edge and sets the mode to 0.
- R8: A software call request raises a trap with cause 2'b01 at the next edge in either mode, and the mode becomes 0.
- R9: A memory fault raises a trap with cause 2'b11 at the next edge, and the mode becomes 0.
- R10: The trap output is a single-cycle pulse. It is 0 in any cycle that follows a cycle with no trap event.
- R11: When a trap event and an enter-user request fall in the same cycle, the trap is raised and the mode is 0 afterwards.
- R12: When several trap events coincide, the reported cause is the highest by priority: fault 2'b11 over illegal 2'b10 over software call 2'b01 over interrupt 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Decoded instruction present this cycle |
| instr_priv | input | 1 | The present instruction is privileged |
| set_user_req | input | 1 | Request to enter user mode (privileged) |
| syscall_req | input | 1 | Software call request |
| irq | input | IRQ_LINES | External interrupt lines, level |
| mem_fault | input | 1 | Memory access fault |
| mode_o | output | 1 | Current mode: 0 supervisor, 1 user |
| exec_en_o | output | 1 | Instruction in flight may execute |
| trap_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 2 | Cause of the trap request |

## Verification
The hardest situation to reach is a coincidence of events while the block sits in user mode. One example is an illegal privileged instruction, a software call and an interrupt all in the same cycle. Another is a fault arriving together with an enter-user request. Every trap throws the mode back to supervisor, so each such test needs a fresh enter-user cycle first. The stimulus table therefore puts a set-user row in front of every user-mode scenario, and the table is walked in order so that the mode carries from row to row.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int CAUSE_W = 2;
  localparam int NUM_SRC = 1 << CAUSE_W;

  localparam logic MODE_SUP  = 1'b0;
  localparam logic MODE_USER = 1'b1;

  // Cause codes double as arbitration priority: larger index wins.
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ     = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 2'b10;
  localparam logic [CAUSE_W-1:0] CAUSE_FAULT   = 2'b11;
endpackage

// File: rtl/pm_reset_sync.sv
module pm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_priv_guard.sv
module pm_priv_guard (
  input  logic mode,
  input  logic instr_valid,
  input  logic instr_priv,
  input  logic set_user_req,
  output logic exec_en,
  output logic illegal,
  output logic set_user_ok
);
  import priv_pkg::*;

  logic in_user;
  logic priv_instr_blocked;
  logic set_user_blocked;

  always_comb begin
    in_user            = (mode == MODE_USER);
    priv_instr_blocked = instr_valid && instr_priv && in_user;
    set_user_blocked   = set_user_req && in_user;
    illegal            = priv_instr_blocked || set_user_blocked;
    exec_en            = instr_valid && !priv_instr_blocked;
    set_user_ok        = set_user_req && !in_user;
  end
endmodule

// File: rtl/pm_trap_arbiter.sv
module pm_trap_arbiter #(
  parameter int NSRC = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src_req,
  output logic             any_req,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    any_req = |src_req;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_req[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_any,
  input  logic [CW-1:0] trap_cause,
  input  logic          set_user_ok,
  output logic          mode,
  output logic          trap_pulse,
  output logic [CW-1:0] cause
);
  import priv_pkg::*;

  logic          mode_q, mode_d;
  logic          trap_q, trap_d;
  logic [CW-1:0] cause_q, cause_d;
  logic          cause_en;

  always_comb begin
    mode_d = mode_q;
    if (trap_any)         mode_d = MODE_SUP;
    else if (set_user_ok) mode_d = MODE_USER;
    trap_d   = trap_any;
    cause_en = trap_any;
    cause_d  = trap_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SUP;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      mode_q <= mode_d;
      trap_q <= trap_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign mode       = mode_q;
  assign trap_pulse = trap_q;
  assign cause      = cause_q;
endmodule

// File: rtl/privilege_mode_unit.sv
module privilege_mode_unit #(
  parameter int IRQ_LINES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic                 instr_priv,
  input  logic                 set_user_req,
  input  logic                 syscall_req,
  input  logic [IRQ_LINES-1:0] irq,
  input  logic                 mem_fault,
  output logic                 mode_o,
  output logic                 exec_en_o,
  output logic                 trap_o,
  output logic [1:0]           trap_cause_o
);
  import priv_pkg::*;

  logic                rst_sync_n;
  logic                mode;
  logic                illegal;
  logic                set_user_ok;
  logic [NUM_SRC-1:0]  src_req;
  logic                trap_any;
  logic [CAUSE_W-1:0]  trap_cause;

  pm_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pm_priv_guard u_guard (
    .mode         (mode),
    .instr_valid  (instr_valid),
    .instr_priv   (instr_priv),
    .set_user_req (set_user_req),
    .exec_en      (exec_en_o),
    .illegal      (illegal),
    .set_user_ok  (set_user_ok)
  );

  always_comb begin
    src_req                = '0;
    src_req[CAUSE_IRQ]     = |irq;
    src_req[CAUSE_SYSCALL] = syscall_req;
    src_req[CAUSE_ILLEGAL] = illegal;
    src_req[CAUSE_FAULT]   = mem_fault;
  end

  pm_trap_arbiter #(.NSRC(NUM_SRC)) u_arb (
    .src_req (src_req),
    .any_req (trap_any),
    .win_idx (trap_cause)
  );

  pm_mode_ctrl #(.CW(CAUSE_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .trap_any    (trap_any),
    .trap_cause  (trap_cause),
    .set_user_ok (set_user_ok),
    .mode        (mode),
    .trap_pulse  (trap_o),
    .cause       (trap_cause_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int IRQ_LINES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 instr_valid,
  input logic                 instr_priv,
  input logic                 set_user_req,
  input logic                 syscall_req,
  input logic [IRQ_LINES-1:0] irq,
  input logic                 mem_fault,
  input logic                 mode_o,
  input logic                 exec_en_o,
  input logic                 trap_o,
  input logic [1:0]           trap_cause_o
);
  AST_TRAP_TO_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mode_o); // R7
  AST_USER_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_priv && mode_o) |-> !exec_en_o); // R5
  AST_USER_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_priv && mode_o && !mem_fault) |=> (trap_o && trap_cause_o == 2'b10)); // R5
  AST_SUP_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !mode_o) |-> exec_en_o); // R3
  AST_NO_EXEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !exec_en_o); // R4
  AST_USER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> ($past(set_user_req) && !trap_o)); // R2
  AST_SYSCALL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_req |=> trap_o); // R8
  AST_FAULT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |=> (trap_o && trap_cause_o == 2'b11)); // R9
  AST_IRQ_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> trap_o); // R7
  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_user_req && (syscall_req || mem_fault || (|irq))) |=> !mode_o); // R11
  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!syscall_req && !mem_fault && !(|irq) && !set_user_req && !instr_valid) |=> !trap_o); // R10
endmodule

bind privilege_mode_unit pmu_checker #(.IRQ_LINES(IRQ_LINES)) u_pmu_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .instr_valid  (instr_valid),
  .instr_priv   (instr_priv),
  .set_user_req (set_user_req),
  .syscall_req  (syscall_req),
  .irq          (irq),
  .mem_fault    (mem_fault),
  .mode_o       (mode_o),
  .exec_en_o    (exec_en_o),
  .trap_o       (trap_o),
  .trap_cause_o (trap_cause_o)
);

// File: tb/privilege_mode_unit_bench.sv
module privilege_mode_unit_bench;
  localparam int IRQ_LINES = 4;
  localparam int NVEC = 21;

  logic                 clk;
  logic                 rst_n;
  logic                 instr_valid, instr_priv, set_user_req, syscall_req, mem_fault;
  logic [IRQ_LINES-1:0] irq;
  logic                 mode_o, exec_en_o, trap_o;
  logic [1:0]           trap_cause_o;

  int n_checks = 0;
  int n_fail   = 0;

  privilege_mode_unit #(.IRQ_LINES(IRQ_LINES)) u_privilege_mode_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_priv(instr_priv),
    .set_user_req(set_user_req), .syscall_req(syscall_req), .irq(irq),
    .mem_fault(mem_fault), .mode_o(mode_o), .exec_en_o(exec_en_o),
    .trap_o(trap_o), .trap_cause_o(trap_cause_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  // {req[14:11], su, iv, ip, sc, irq, flt, exp_exec, exp_mode, exp_trap, exp_cause[1:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd1,  6'b000000, 5'b0_0_0_00}, // R1 idle after reset
    {4'd3,  6'b011000, 5'b1_0_0_00}, // R3 priv in supervisor
    {4'd4,  6'b010000, 5'b1_0_0_00}, // R4 plain instr, supervisor
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2 enter user
    {4'd4,  6'b010000, 5'b1_1_0_00}, // R4 plain instr, user
    {4'd5,  6'b011000, 5'b0_0_1_10}, // R5 priv in user
    {4'd10, 6'b000000, 5'b0_0_0_00}, // R10 pulse ends
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2
    {4'd6,  6'b100000, 5'b0_0_1_10}, // R6 enter-user from user
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2
    {4'd7,  6'b000010, 5'b0_0_1_00}, // R7 irq in user
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2
    {4'd8,  6'b000100, 5'b0_0_1_01}, // R8 syscall in user
    {4'd8,  6'b000100, 5'b0_0_1_01}, // R8 syscall in supervisor
    {4'd9,  6'b000001, 5'b0_0_1_11}, // R9 fault
    {4'd11, 6'b100010, 5'b0_0_1_00}, // R11 enter-user with irq
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2
    {4'd12, 6'b011110, 5'b0_0_1_10}, // R12 illegal over syscall and irq
    {4'd2,  6'b100000, 5'b0_1_0_00}, // R2
    {4'd12, 6'b011101, 5'b0_0_1_11}, // R12 fault over illegal and syscall
    {4'd10, 6'b000000, 5'b0_0_0_00}  // R10
  };

  task automatic check(input int req, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    instr_valid = 0; instr_priv = 0; set_user_req = 0;
    syscall_req = 0; irq = '0; mem_fault = 0;
  endtask

  // Drive at negedge, check exec before the edge, registered outputs after it.
  task automatic step(input int req, input logic su, iv, ip, sc, input logic [IRQ_LINES-1:0] iq,
                      input logic flt, input logic e_exec, e_mode, e_trap, input logic [1:0] e_cause);
    @(negedge clk);
    set_user_req = su; instr_valid = iv; instr_priv = ip;
    syscall_req = sc; irq = iq; mem_fault = flt;
    #2;
    check(req, "exec_en", {1'b0, exec_en_o}, {1'b0, e_exec});
    @(posedge clk);
    #2;
    check(req, "mode", {1'b0, mode_o}, {1'b0, e_mode});
    check(req, "trap", {1'b0, trap_o}, {1'b0, e_trap});
    if (e_trap) check(req, "cause", trap_cause_o, e_cause);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    check(1, "mode in reset", {1'b0, mode_o}, 2'b00); // R1
    check(1, "trap in reset", {1'b0, trap_o}, 2'b00); // R1
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(int'(VEC[i][14:11]), VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7],
           {{(IRQ_LINES-1){1'b0}}, VEC[i][6]}, VEC[i][5],
           VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
    end

    // R7: highest interrupt line alone
    step(2, 1, 0, 0, 0, '0, 0, 0, 1, 0, 2'b00);
    step(7, 0, 0, 0, 0, {1'b1, {(IRQ_LINES-1){1'b0}}}, 0, 0, 0, 1, 2'b00);
    // R4: no instruction valid, user mode
    step(2, 1, 0, 0, 0, '0, 0, 0, 1, 0, 2'b00);
    step(4, 0, 0, 1, 0, '0, 0, 0, 1, 0, 2'b00);
    // R11: fault together with enter-user from supervisor
    step(2, 0, 0, 0, 1, '0, 0, 0, 0, 1, 2'b01);
    step(11, 1, 0, 0, 0, '0, 1, 0, 0, 1, 2'b11);

    // R1: asynchronous reset from user mode
    step(2, 1, 0, 0, 0, '0, 0, 0, 1, 0, 2'b00);
    @(negedge clk); idle_inputs();
    #3 rst_n = 0;
    #1;
    check(1, "mode on async reset", {1'b0, mode_o}, 2'b00); // R1
    check(1, "trap on async reset", {1'b0, trap_o}, 2'b00); // R1
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    check(1, "mode after release", {1'b0, mode_o}, 2'b00); // R1

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule